// File: doc/BRIEF.md
# Low-Power Interval Timer with Dual Compare

This block is a 16-bit up-counting timer for always-on, low-power use. It advances from one of two slow timing sources. Each source reaches the block as a single-cycle tick strobe that is already synchronous to the system clock. A power-of-two prescaler divides the chosen source, so software can trade resolution for range.

Three events can request an interrupt: the counter rolling over, and the counter stepping onto either of two independently programmed compare values. Each event has its own sticky flag, its own "missed" bit and its own mask bit. All of them sit behind a small word-wide register port with a combinational read path. The block drives a single level interrupt line that stays high while any unmasked flag is pending.

Register map (word address on `bus_addr`):

| Address | Register | Contents |
|---|---|---|
| 0 | control | bit 0 run, bit 1 source, bits 7:4 prescale shift |
| 1 | count | counter value |
| 2 | target A | compare-A value |
| 3 | target B | compare-B value |
| 4 | status | flags in bits 2:0, missed bits in bits 6:4 |
| 5 | mask | enable bits in bits 2:0 |

Cause order in the status and mask registers is: wrap in bit 0, compare A in bit 1, compare B in bit 2.

Top module: `lt_timer`

## Requirements
- R1: While running, the 16-bit counter increases by exactly one on each prescaled step, and the new value is readable at address 1 after the clock edge that takes the step.
- R2: Bit 1 of the control register (address 0) picks the source. 0 selects `tick_rc` and 1 selects `tick_xo`. Strobes on the source that is not selected have no effect on the count.
- R3: Bits 7:4 of the control register hold a shift N. The counter steps once every 2^N selected ticks. A control write that changes bit 0 from 0 to 1 restarts the divider, so the first step comes after 2^N ticks.
- R4: When control bit 0 (run) is 0, the counter holds its value and no step occurs.
- R5: A step from 0xFFFF to 0x0000 sets the wrap flag, status bit 0.
- R6: A step onto the value in target A (address 2) sets status bit 1. A step onto the value in target B (address 3) sets status bit 2. Both targets are checked on every step, independently of each other.
- R7: Flags are set regardless of the mask and are sticky. Writing 1 to a status bit 2:0 clears that flag. If a cause fires in the same cycle as its clear, the flag is set.
- R8: If a cause fires while its flag is already set, the matching missed bit is set (status bit 4 for wrap, bit 5 for compare A, bit 6 for compare B). Writing 1 to that bit clears it.
- R9: `irq` is high exactly when some status bit 2:0 is set together with the same bit of the mask register (address 5). It stays high until the flag or the mask bit is cleared.
- R10: A write to address 1 loads the counter directly and wins over a step in the same cycle. A loaded value never sets a flag, even when it equals a target.
- R11: After reset every register reads 0. Control reads back bit 0, bit 1 and bits 7:4, with the other bits 0. Mask reads back bits 2:0. Addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_rc | input | 1 | One-cycle strobe from the ~1 kHz internal RC source |
| tick_xo | input | 1 | One-cycle strobe from the 32.768 kHz source |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt request |

## Verification
A tick or write presented before a rising edge changes the counter, flags and missed bits on that same edge. `bus_rdata` and `irq` follow combinationally, so each result is due one edge after its stimulus. The bench drives inputs just after each rising edge and compares against its reference model at the following falling edge. By then exactly one edge has been applied to both the reference model and the design. Directed reads use the same half-cycle offset, so every value is checked in the first cycle it is due.

// File: rtl/lt_pkg.sv
package lt_pkg;

  typedef enum logic [2:0] {
    RA_CTRL  = 3'd0,
    RA_COUNT = 3'd1,
    RA_CMPA  = 3'd2,
    RA_CMPB  = 3'd3,
    RA_STAT  = 3'd4,
    RA_MASK  = 3'd5
  } lt_addr_e;

  localparam int NCAUSE     = 3;
  localparam int CAUSE_WRAP = 0;
  localparam int CAUSE_CMPA = 1;
  localparam int CAUSE_CMPB = 2;
  localparam int MISS_LSB   = 4;
  localparam int PSC_LSB    = 4;

endpackage

// File: rtl/lt_prescaler.sv
module lt_prescaler #(
  parameter int PSC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic             src_sel,
  input  logic             tick_rc,
  input  logic             tick_xo,
  input  logic [PSC_W-1:0] shift,
  output logic             step
);
  localparam int DIV_W = (1 << PSC_W) - 1;

  // True when the low n bits of div are all ones (n = 0 always true)
  function automatic logic low_bits_full(input logic [DIV_W-1:0] div,
                                         input logic [PSC_W-1:0] n);
    logic [DIV_W-1:0] msk;
    msk = ~({DIV_W{1'b1}} << n);
    return (div & msk) == msk;
  endfunction

  logic [DIV_W-1:0] div_q;
  logic             src_tick;

  assign src_tick = src_sel ? tick_xo : tick_rc;
  assign step     = run && src_tick && low_bits_full(div_q, shift);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                div_q <= '0;
    else if (restart)          div_q <= '0;
    else if (run && src_tick)  div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/lt_counter.sv
module lt_counter #(
  parameter int CNT_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      step,
  input  logic                      load,
  input  logic [CNT_W-1:0]          load_val,
  input  logic [CNT_W-1:0]          cmp_a,
  input  logic [CNT_W-1:0]          cmp_b,
  output logic [CNT_W-1:0]          count,
  output logic [lt_pkg::NCAUSE-1:0] ev
);
  import lt_pkg::*;

  function automatic logic [CNT_W-1:0] next_val(input logic [CNT_W-1:0] v);
    return v + 1'b1;
  endfunction

  logic             advance;
  logic [CNT_W-1:0] nxt;

  assign advance = step && !load;
  assign nxt     = next_val(count);

  always_comb begin
    ev             = '0;
    ev[CAUSE_WRAP] = advance && (count == {CNT_W{1'b1}});
    ev[CAUSE_CMPA] = advance && (nxt == cmp_a);
    ev[CAUSE_CMPB] = advance && (nxt == cmp_b);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (load)    count <= load_val;
    else if (advance) count <= nxt;
  end
endmodule

// File: rtl/lt_cause_bank.sv
module lt_cause_bank #(
  parameter int NC = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NC-1:0] ev,
  input  logic [NC-1:0] clr_flag,
  input  logic [NC-1:0] clr_miss,
  output logic [NC-1:0] flag,
  output logic [NC-1:0] miss
);
  for (genvar i = 0; i < NC; i++) begin : g_cause
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag[i] <= 1'b0;
        miss[i] <= 1'b0;
      end else begin
        flag[i] <= (flag[i] && !clr_flag[i]) || ev[i];
        miss[i] <= (miss[i] && !clr_miss[i]) || (ev[i] && flag[i]);
      end
    end
  end
endmodule

// File: rtl/lt_timer.sv
module lt_timer #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_rc,
  input  logic             tick_xo,
  input  logic             bus_wr,
  input  logic [2:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             irq
);
  import lt_pkg::*;

  logic             en_q, src_q;
  logic [PSC_W-1:0] psc_q;
  logic [CNT_W-1:0] cmpa_q, cmpb_q, count_q;
  logic [NCAUSE-1:0] mask_q, flag, miss, ev;
  logic             wr_ctrl, wr_count, wr_cmpa, wr_cmpb, wr_stat, wr_mask;
  logic             restart, step;

  assign wr_ctrl  = bus_wr && (bus_addr == RA_CTRL);
  assign wr_count = bus_wr && (bus_addr == RA_COUNT);
  assign wr_cmpa  = bus_wr && (bus_addr == RA_CMPA);
  assign wr_cmpb  = bus_wr && (bus_addr == RA_CMPB);
  assign wr_stat  = bus_wr && (bus_addr == RA_STAT);
  assign wr_mask  = bus_wr && (bus_addr == RA_MASK);
  assign restart  = wr_ctrl && bus_wdata[0] && !en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      src_q  <= 1'b0;
      psc_q  <= '0;
      cmpa_q <= '0;
      cmpb_q <= '0;
      mask_q <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= bus_wdata[0];
        src_q <= bus_wdata[1];
        psc_q <= bus_wdata[PSC_LSB +: PSC_W];
      end
      if (wr_cmpa) cmpa_q <= bus_wdata;
      if (wr_cmpb) cmpb_q <= bus_wdata;
      if (wr_mask) mask_q <= bus_wdata[NCAUSE-1:0];
    end
  end

  lt_prescaler #(.PSC_W(PSC_W)) i_psc (
    .clk(clk), .rst_n(rst_n), .run(en_q), .restart(restart),
    .src_sel(src_q), .tick_rc(tick_rc), .tick_xo(tick_xo),
    .shift(psc_q), .step(step)
  );

  lt_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .load(wr_count),
    .load_val(bus_wdata), .cmp_a(cmpa_q), .cmp_b(cmpb_q),
    .count(count_q), .ev(ev)
  );

  lt_cause_bank #(.NC(NCAUSE)) i_bank (
    .clk(clk), .rst_n(rst_n), .ev(ev),
    .clr_flag({NCAUSE{wr_stat}} & bus_wdata[NCAUSE-1:0]),
    .clr_miss({NCAUSE{wr_stat}} & bus_wdata[MISS_LSB +: NCAUSE]),
    .flag(flag), .miss(miss)
  );

  assign irq = |(flag & mask_q);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      RA_CTRL: begin
        bus_rdata[0]                 = en_q;
        bus_rdata[1]                 = src_q;
        bus_rdata[PSC_LSB +: PSC_W]  = psc_q;
      end
      RA_COUNT: bus_rdata = count_q;
      RA_CMPA:  bus_rdata = cmpa_q;
      RA_CMPB:  bus_rdata = cmpb_q;
      RA_STAT: begin
        bus_rdata[NCAUSE-1:0]          = flag;
        bus_rdata[MISS_LSB +: NCAUSE]  = miss;
      end
      RA_MASK:  bus_rdata[NCAUSE-1:0] = mask_q;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/lt_timer_chk.sv
module lt_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_q,
  input logic             step,
  input logic             wr_count,
  input logic             wr_mask,
  input logic [CNT_W-1:0] bus_wdata,
  input logic [CNT_W-1:0] count_q,
  input logic [2:0]       ev,
  input logic [2:0]       flag,
  input logic [2:0]       miss,
  input logic             irq
);
  AST_STEP_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> en_q); // R4
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !wr_count) |=> $stable(count_q)); // R4
  AST_STEP_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_count) |=> count_q == CNT_W'($past(count_q) + 1'b1)); // R1
  AST_WRAP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_count && count_q == {CNT_W{1'b1}}) |=> flag[0]); // R5
  AST_LOAD_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wr_count |=> (flag & ~$past(flag)) == 3'b000); // R10
  AST_MISS_ON_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev & flag) != 3'b000) |=> (miss & $past(ev & flag)) == $past(ev & flag)); // R8
  AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != 3'b000) |=> (flag & $past(ev)) == $past(ev)); // R7
  AST_IRQ_MASKED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask && bus_wdata[2:0] == 3'b000) |=> !irq); // R9
endmodule

bind lt_timer lt_timer_chk #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .step(step), .wr_count(wr_count),
  .wr_mask(wr_mask), .bus_wdata(bus_wdata), .count_q(count_q), .ev(ev),
  .flag(flag), .miss(miss), .irq(irq)
);

// File: tb/test_lt_timer.sv
`timescale 1ns/1ps
module test_lt_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_rc = 1'b0, tick_xo = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic        irq;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  lt_timer i_lt_timer (
    .clk(clk), .rst_n(rst_n), .tick_rc(tick_rc), .tick_xo(tick_xo),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  int m_cnt, m_cmpa, m_cmpb, m_mask, m_ctrl, m_ticks;
  bit m_flag[3], m_miss[3];

  function automatic int m_read(input int a);
    int v;
    case (a)
      0: return m_ctrl;
      1: return m_cnt;
      2: return m_cmpa;
      3: return m_cmpb;
      4: begin
        v = 0;
        for (int i = 0; i < 3; i++) begin
          if (m_flag[i]) v += (1 << i);
          if (m_miss[i]) v += (16 << i);
        end
        return v;
      end
      5: return m_mask;
      default: return 0;
    endcase
  endfunction

  function automatic bit m_irq();
    for (int i = 0; i < 3; i++)
      if (m_flag[i] && ((m_mask >> i) & 1) == 1) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_cmpa = 0; m_cmpb = 0; m_mask = 0; m_ctrl = 0; m_ticks = 0;
      for (int i = 0; i < 3; i++) begin m_flag[i] = 0; m_miss[i] = 0; end
    end else begin
      bit stp, ld, tk;
      bit evs[3];
      int nx, sh, wd;
      wd = int'(bus_wdata);
      sh = (m_ctrl >> 4) & 15;
      tk = ((m_ctrl >> 1) & 1) == 1 ? tick_xo : tick_rc;
      stp = 0;
      if ((m_ctrl & 1) == 1 && tk) begin
        m_ticks++;
        if (m_ticks % (1 << sh) == 0) stp = 1;
      end
      ld = bus_wr && bus_addr == 3'd1;
      nx = (m_cnt + 1) % 65536;
      evs[0] = stp && !ld && m_cnt == 65535;
      evs[1] = stp && !ld && nx == m_cmpa;
      evs[2] = stp && !ld && nx == m_cmpb;
      for (int i = 0; i < 3; i++) begin
        bit cf, cm;
        cf = bus_wr && bus_addr == 3'd4 && ((wd >> i) & 1) == 1;
        cm = bus_wr && bus_addr == 3'd4 && ((wd >> (4 + i)) & 1) == 1;
        m_miss[i] = (m_miss[i] && !cm) || (evs[i] && m_flag[i]);
        m_flag[i] = (m_flag[i] && !cf) || evs[i];
      end
      if (ld) m_cnt = wd; else if (stp) m_cnt = nx;
      if (bus_wr) begin
        case (bus_addr)
          3'd0: begin
            if ((wd & 1) == 1 && (m_ctrl & 1) == 0) m_ticks = 0;
            m_ctrl = wd & 16'h00F3;
          end
          3'd2: m_cmpa = wd;
          3'd3: m_cmpb = wd;
          3'd5: m_mask = wd & 7;
          default: ;
        endcase
      end
    end
  end

  function automatic string tag_of(input int a);
    case (a)
      1: return "R1";
      4: return "R7";
      5: return "R9";
      default: return "R11";
    endcase
  endfunction

  // per-cycle comparison, half a cycle after each edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      total++;
      if (int'(bus_rdata) != m_read(int'(bus_addr))) begin
        bad++;
        $display("FAIL %s model addr=%0d actual=%h expected=%h", tag_of(int'(bus_addr)),
                 bus_addr, bus_rdata, m_read(int'(bus_addr)));
      end
      total++;
      if (irq != m_irq()) begin
        bad++;
        $display("FAIL R9 model irq actual=%0b expected=%0b", irq, m_irq());
      end
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic ticks(input bit rc, input bit xo, input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      tick_rc = rc; tick_xo = xo;
    end
    @(posedge clk); #1;
    tick_rc = 1'b0; tick_xo = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [15:0] exp, input string tag);
    @(posedge clk); #1;
    bus_addr = a;
    @(negedge clk);
    total++;
    if (bus_rdata !== exp) begin
      bad++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, bus_rdata, exp);
    end
  endtask

  task automatic irq_chk(input logic exp, input string tag);
    @(negedge clk);
    total++;
    if (irq !== exp) begin
      bad++;
      $display("FAIL %s irq actual=%0b expected=%0b", tag, irq, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    for (int a = 0; a < 8; a++) rd_chk(3'(a), 16'h0000, "R11");   // reset state
    irq_chk(1'b0, "R11");

    wr(3'd2, 16'd5); wr(3'd3, 16'd3); wr(3'd5, 16'd0);
    wr(3'd0, 16'h0001);                       // run, RC source, N=0
    rd_chk(3'd0, 16'h0001, "R11");
    ticks(1'b0, 1'b1, 4);                     // unselected source
    rd_chk(3'd1, 16'd0, "R2");
    ticks(1'b1, 1'b0, 6);
    rd_chk(3'd1, 16'd6, "R1");
    rd_chk(3'd4, 16'h0006, "R6");             // both compares hit, wrap not
    irq_chk(1'b0, "R7");                      // flags set yet masked
    wr(3'd5, 16'h0002);
    irq_chk(1'b1, "R9");
    wr(3'd4, 16'h0002);                       // clear compare-A flag
    rd_chk(3'd4, 16'h0004, "R7");
    irq_chk(1'b0, "R9");

    wr(3'd0, 16'h0000);                       // stop
    ticks(1'b1, 1'b0, 5);
    rd_chk(3'd1, 16'd6, "R4");

    wr(3'd0, 16'h0021);                       // run, N=2, divider restarts
    ticks(1'b1, 1'b0, 3);
    rd_chk(3'd1, 16'd6, "R3");
    ticks(1'b1, 1'b0, 8);
    rd_chk(3'd1, 16'd8, "R3");

    wr(3'd1, 16'hFFFE);
    rd_chk(3'd1, 16'hFFFE, "R10");
    wr(3'd0, 16'h0003);                       // XO source, N=0
    ticks(1'b0, 1'b1, 2);
    rd_chk(3'd1, 16'h0000, "R5");
    rd_chk(3'd4, 16'h0005, "R5");
    ticks(1'b0, 1'b1, 3);                     // hits target B again
    rd_chk(3'd4, 16'h0045, "R8");
    wr(3'd4, 16'h0040);
    rd_chk(3'd4, 16'h0005, "R8");

    wr(3'd1, 16'd5);                          // load onto target A
    rd_chk(3'd4, 16'h0005, "R10");
    ticks(1'b0, 1'b1, 1);
    rd_chk(3'd1, 16'd6, "R1");
    rd_chk(3'd4, 16'h0005, "R6");

    wr(3'd5, 16'h0000);
    irq_chk(1'b0, "R9");
    repeat (4) @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule